// File: doc/BRIEF.md
# Low-Frequency RFID Downlink Gap Encoder

This block sends one reader-to-tag command over a low-frequency carrier. The carrier is switched off for fixed stretches. Every duration is counted in carrier-cycle ticks, where one tick is one carrier period of about 8 us. The host side supplies four things and then pulses `start` for one clock:

- a command select,
- a 6-bit word address,
- a 32-bit data word,
- a 32-bit password word, with an optional password flag.

The block then builds the frame from the command code, the address with its parity bit, and the data or password bits. It drives `field_en` directly, and a high `field_en` means the carrier is on.

A frame opens with a long carrier-off start gap, which replaces the first stored bit. Every later bit becomes a fixed pattern of carrier-on and carrier-off stretches. After a login or write frame, the block holds the carrier on for a programming wait before it finishes.

For read and write, the password flag places a complete login frame in front of the command frame. While a command is in progress, `busy` stays high. A single-cycle `done` pulse marks its end. Between commands the carrier stays on.

Top module: `rfid_dl_encoder`

## Requirements
- R1: During and after reset and while idle, `field_en` is 1, `busy` is 0 and `done` is 0. A reset applied in the middle of a frame returns the block to this state at once.
- R2: A frame starts with `field_en` low for 56 ticks and then high for 16 ticks. Stored bit 0 of the frame is a placeholder 0 that is never sent as a symbol. Gap lengths count ticks only.
- R3: Each sent bit of value 1 is `field_en` high for 32 ticks. Each sent bit of value 0 is `field_en` low for 16 ticks followed by high for 16 ticks.
- R4: `cmd_sel` selects the command: 0 is login (code 0xC), 1 is write (0xA), 2 is read (0x9) and 3 is disable (0x5). The 4 code bits follow the placeholder and are sent code bit 0 first.
- R5: Read and write frames send the 6 address bits, address bit 0 first, followed by one parity bit. The parity bit is the XOR of the 6 address bits, which gives even parity over 7 bits.
- R6: The frame contents are: login = code then the 32-bit word; read = code then address and parity; write = code, then address and parity, then the 32-bit data; disable = code only.
- R7: A 32-bit word is sent least significant bit first, so the low 16-bit half goes before the high half. Login frames carry `pass_word`. Write frames carry `data_word`.
- R8: After a login or write frame, `field_en` stays high for a further 2500 ticks before the block finishes or starts the next frame. Read and disable frames have no such wait.
- R9: With `use_pwd` = 1 and a read or write command, a full login frame carrying `pass_word` is sent first, including its 2500-tick wait, and the command frame follows. For login and disable, `use_pwd` has no effect.
- R10: `busy` rises on the clock edge that accepts `start` and stays high until the final tick of the command. On that edge `busy` falls and `done` is 1 for exactly one clock.
- R11: A `start` pulse while `busy` is high is ignored. Input changes during a command do not alter the waveform in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per carrier cycle |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmd_sel | input | 2 | Command select: 0 login, 1 write, 2 read, 3 disable |
| use_pwd | input | 1 | Send a login frame before read or write |
| addr | input | ADDR_W (6) | Word address |
| data_word | input | DATA_W (32) | Data for write |
| pass_word | input | DATA_W (32) | Password for login frames |
| field_en | output | 1 | Carrier enable, 1 = carrier on |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The hardest situation to reach is the junction between two frames of one password-mode command. There, the 2500-tick wait of the login frame must flow straight into the start gap of the command frame, and `busy` must not drop and no `done` must appear. The stimulus reaches it by running read and write entries with `use_pwd` set. The bench compares every tick sample against a gap sequence that it builds from the two frames and chains together. Two further cases are set up on purpose: a second `start` with a different command is injected in the middle of a frame, and a reset is applied part-way through a write.

// File: rtl/rfid_dl_pkg.sv
package rfid_dl_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CMD_LOGIN   = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_READ    = 2'd2,
    CMD_DISABLE = 2'd3
  } dl_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_OFF,
    ST_START_ON,
    ST_SYM_OFF,
    ST_SYM_ON,
    ST_HOLD
  } dl_state_e;

  // Codes are stored pre-mirrored with parity, transmitted bit 0 first.
  function automatic logic [CODE_W-1:0] cmd_code(dl_cmd_e c);
    case (c)
      CMD_LOGIN:   return 4'hC;
      CMD_WRITE:   return 4'hA;
      CMD_READ:    return 4'h9;
      default:     return 4'h5;
    endcase
  endfunction

endpackage

// File: rtl/rfid_dl_framer.sv
module rfid_dl_framer
  import rfid_dl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 1 + CODE_W + ADDR_W + 1 + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  dl_cmd_e             kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   word,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    len,
  output logic                needs_hold
);
  localparam int A_POS  = 1 + CODE_W;
  localparam int P_POS  = A_POS + ADDR_W;
  localparam int WD_POS = P_POS + 1;

  always_comb begin
    frame      = '0;
    frame[1 +: CODE_W] = cmd_code(kind);
    needs_hold = 1'b0;
    len        = LEN_W'(1 + CODE_W);
    case (kind)
      CMD_LOGIN: begin
        frame[A_POS +: DATA_W] = word;
        len        = LEN_W'(A_POS + DATA_W);
        needs_hold = 1'b1;
      end
      CMD_READ: begin
        frame[A_POS +: ADDR_W] = addr;
        frame[P_POS]           = ^addr;
        len = LEN_W'(WD_POS);
      end
      CMD_WRITE: begin
        frame[A_POS +: ADDR_W]  = addr;
        frame[P_POS]            = ^addr;
        frame[WD_POS +: DATA_W] = word;
        len        = LEN_W'(WD_POS + DATA_W);
        needs_hold = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rfid_dl_gap_timer.sv
module rfid_dl_gap_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == '0);

  // R2: durations advance only on carrier ticks
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/rfid_dl_encoder.sv
module rfid_dl_encoder
  import rfid_dl_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int START_TICKS = 56,
  parameter int ONE_TICKS   = 32,
  parameter int ZERO_TICKS  = 16,
  parameter int POST_TICKS  = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [1:0]        cmd_sel,
  input  logic              use_pwd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_word,
  input  logic [DATA_W-1:0] pass_word,
  output logic              field_en,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = 1 + CODE_W + ADDR_W + 1 + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int MAX_A   = (START_TICKS > ONE_TICKS) ? START_TICKS : ONE_TICKS;
  localparam int MAX_B   = (ZERO_TICKS > POST_TICKS) ? ZERO_TICKS : POST_TICKS;
  localparam int MAX_G   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_G + 1);

  dl_state_e         state, n_state;
  logic              field_q, n_field, busy_q, n_busy, done_q, n_done;
  logic              prelude, n_pre, latch, frame_end;
  logic [LEN_W-1:0]  bit_idx, n_idx;
  dl_cmd_e           cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, pass_q;

  dl_cmd_e           kind;
  logic [DATA_W-1:0] word;
  logic [FRAME_W-1:0] frame, shifted;
  logic [LEN_W-1:0]  len;
  logic              needs_hold, expire, tload, cur_bit;
  logic [CNT_W-1:0]  tval;

  assign kind    = prelude ? CMD_LOGIN : cmd_q;
  assign word    = (kind == CMD_LOGIN) ? pass_q : data_q;
  assign shifted = frame >> bit_idx;
  assign cur_bit = shifted[0];

  rfid_dl_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W))
    u_framer (.kind(kind), .addr(addr_q), .word(word), .frame(frame),
              .len(len), .needs_hold(needs_hold));

  rfid_dl_gap_timer #(.CNT_W(CNT_W))
    u_timer (.clk(clk), .rst(rst), .tick(tick), .load(tload),
             .load_val(tval), .expire(expire));

  always_comb begin
    n_state = state;  n_field = field_q;  n_busy = busy_q;  n_done = 1'b0;
    n_idx = bit_idx;  n_pre = prelude;    latch = 1'b0;     frame_end = 1'b0;
    tload = 1'b0;     tval = '0;
    case (state)
      ST_IDLE: begin
        n_field = 1'b1;
        if (start) begin
          latch   = 1'b1;
          n_busy  = 1'b1;
          n_pre   = use_pwd && (cmd_sel == 2'd1 || cmd_sel == 2'd2);
          n_state = ST_START_OFF;
          n_field = 1'b0;
          tload   = 1'b1;
          tval    = CNT_W'(START_TICKS - 1);
          n_idx   = LEN_W'(1);
        end
      end
      ST_START_OFF, ST_SYM_OFF: if (expire) begin
        n_state = (state == ST_START_OFF) ? ST_START_ON : ST_SYM_ON;
        n_field = 1'b1;
        tload   = 1'b1;
        tval    = CNT_W'(ZERO_TICKS - 1);
      end
      ST_START_ON, ST_SYM_ON: if (expire) begin
        if (bit_idx < len) begin
          n_idx = bit_idx + 1'b1;
          tload = 1'b1;
          if (cur_bit) begin
            n_state = ST_SYM_ON;  n_field = 1'b1;  tval = CNT_W'(ONE_TICKS - 1);
          end else begin
            n_state = ST_SYM_OFF; n_field = 1'b0;  tval = CNT_W'(ZERO_TICKS - 1);
          end
        end else if (needs_hold) begin
          n_state = ST_HOLD;
          n_field = 1'b1;
          tload   = 1'b1;
          tval    = CNT_W'(POST_TICKS - 1);
        end else begin
          frame_end = 1'b1;
        end
      end
      ST_HOLD: if (expire) frame_end = 1'b1;
      default: n_state = ST_IDLE;
    endcase

    if (frame_end) begin
      if (prelude) begin
        n_pre   = 1'b0;
        n_state = ST_START_OFF;
        n_field = 1'b0;
        tload   = 1'b1;
        tval    = CNT_W'(START_TICKS - 1);
        n_idx   = LEN_W'(1);
      end else begin
        n_state = ST_IDLE;
        n_field = 1'b1;
        n_busy  = 1'b0;
        n_done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      field_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      prelude <= 1'b0;
      bit_idx <= '0;
      cmd_q   <= CMD_LOGIN;
      addr_q  <= '0;
      data_q  <= '0;
      pass_q  <= '0;
    end else begin
      state   <= n_state;
      field_q <= n_field;
      busy_q  <= n_busy;
      done_q  <= n_done;
      prelude <= n_pre;
      bit_idx <= n_idx;
      if (latch) begin
        cmd_q  <= dl_cmd_e'(cmd_sel);
        addr_q <= addr;
        data_q <= data_word;
        pass_q <= pass_word;
      end
    end
  end

  assign field_en = field_q;
  assign busy     = busy_q;
  assign done     = done_q;

  assert_idle_carrier_on_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> field_q);
  assert_gap_only_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(field_q) |-> busy_q);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: tb/rfid_dl_encoder_tb.sv
module rfid_dl_encoder_tb;
  localparam int START = 56, ONE = 32, ZERO = 16, POST = 2500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmd_sel = 2'd0;
  logic use_pwd = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] data_word = '0, pass_word = '0;
  logic field_en, busy, done;

  always #4 clk = ~clk;
  always_ff @(posedge clk) tick <= ~tick;

  rfid_dl_encoder u_dut (.clk(clk), .rst(rst), .tick(tick), .start(start),
    .cmd_sel(cmd_sel), .use_pwd(use_pwd), .addr(addr), .data_word(data_word),
    .pass_word(pass_word), .field_en(field_en), .busy(busy), .done(done));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic exp_bits [64];
  int exp_len;
  int sample_no, wave_bad, busy_bad, first_idx;
  logic first_act, first_exp;
  bit poke_en;

  // fields: cmd[73:72] pwd[71] addr[70:65] data[64:33] pass[32:1] poke[0]
  localparam logic [73:0] VEC [0:8] = '{
    {2'd0, 1'b0, 6'h00, 32'h0000_0000, 32'hA5C3_0F71, 1'b0},
    {2'd2, 1'b0, 6'h2D, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {2'd2, 1'b0, 6'h07, 32'h0000_0000, 32'h0000_0000, 1'b1},
    {2'd1, 1'b0, 6'h13, 32'h8001_FFFE, 32'h0000_0000, 1'b0},
    {2'd3, 1'b0, 6'h15, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {2'd3, 1'b1, 6'h15, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0},
    {2'd2, 1'b1, 6'h3F, 32'h0000_0000, 32'h1234_5678, 1'b0},
    {2'd1, 1'b1, 6'h01, 32'hDEAD_BEEF, 32'h0000_0001, 1'b0},
    {2'd0, 1'b1, 6'h00, 32'h0000_0000, 32'h0F0F_00FF, 1'b0}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_len] = b;
    exp_len++;
  endtask

  // R4 code table, R5 address+parity, R6 layout, R7 word LSB first
  task automatic build(input int kind, input logic [5:0] a, input logic [31:0] w);
    logic [3:0] code;
    exp_len = 0;
    push(1'b0);
    case (kind)
      0: code = 4'hC;
      1: code = 4'hA;
      2: code = 4'h9;
      default: code = 4'h5;
    endcase
    for (int b = 0; b < 4; b++) push(code[b]);
    if (kind == 1 || kind == 2) begin
      for (int b = 0; b < 6; b++) push(a[b]);
      push(^a);
    end
    if (kind == 0 || kind == 1)
      for (int b = 0; b < 32; b++) push(w[b]);
  endtask

  task automatic expect_run(input logic lvl, input int n);
    for (int k = 0; k < n; k++) begin
      while (!tick) @(negedge clk);
      if (field_en !== lvl) begin
        if (wave_bad == 0) begin
          first_idx = sample_no; first_act = field_en; first_exp = lvl;
        end
        wave_bad++;
      end
      if (busy !== 1'b1) busy_bad++;
      if (poke_en && sample_no == 100) begin
        start = 1'b1; cmd_sel = 2'd3; use_pwd = 1'b0;
      end
      sample_no++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // R2 start gap, R3 symbols, R8 post wait
  task automatic expect_frame(input int kind, input logic [5:0] a, input logic [31:0] w);
    build(kind, a, w);
    expect_run(1'b0, START);
    expect_run(1'b1, ZERO);
    for (int i = 1; i < exp_len; i++) begin
      if (exp_bits[i]) expect_run(1'b1, ONE);
      else begin
        expect_run(1'b0, ZERO);
        expect_run(1'b1, ZERO);
      end
    end
    if (kind == 0 || kind == 1) expect_run(1'b1, POST);
  endtask

  task automatic run_vec(input int idx);
    logic [73:0] v;
    int kind;
    v = VEC[idx];
    kind = int'(v[73:72]);
    @(negedge clk);
    cmd_sel = v[73:72]; use_pwd = v[71]; addr = v[70:65];
    data_word = v[64:33]; pass_word = v[32:1]; poke_en = v[0];
    wave_bad = 0; busy_bad = 0; sample_no = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: login prelude only for read/write with use_pwd
    if (v[71] && (kind == 1 || kind == 2)) expect_frame(0, v[70:65], v[32:1]);
    expect_frame(kind, v[70:65], kind == 0 ? v[32:1] : v[64:33]);
    checks++;
    if (wave_bad != 0) begin
      fails++;
      $display("FAIL R2 R3 R4 R5 R6 R7 R8 R9 R11 vec %0d sample %0d field_en actual %b expected %b",
               idx, first_idx, first_act, first_exp);
    end
    check(busy_bad == 0, $sformatf("R10 busy low during command, vec %0d", idx), busy_bad, 0);
    check(done === 1'b1 && busy === 1'b0 && field_en === 1'b1,
          $sformatf("R10 end state done/busy/field vec %0d", idx),
          {done, busy, field_en}, 3'b101);
    @(negedge clk);
    check(done === 1'b0, $sformatf("R10 done single cycle vec %0d", idx), done, 0);
    poke_en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    poke_en = 1'b0;
    repeat (3) @(negedge clk);
    check(field_en === 1'b1 && busy === 1'b0 && done === 1'b0,
          "R1 reset state field/busy/done", {field_en, busy, done}, 3'b100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(field_en === 1'b1 && busy === 1'b0, "R1 idle carrier on", {field_en, busy}, 2'b10);

    for (int i = 0; i < 9; i++) run_vec(i);

    // R1: reset in the middle of a write
    cmd_sel = 2'd1; use_pwd = 1'b0; addr = 6'h2A; data_word = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    check(busy === 1'b1, "R10 busy mid-frame before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    check(field_en === 1'b1 && busy === 1'b0 && done === 1'b0,
          "R1 mid-frame reset state", {field_en, busy, done}, 3'b100);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    check(field_en === 1'b1 && busy === 1'b0, "R1 stays idle after reset", {field_en, busy}, 2'b10);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired, busy actual %b expected 0", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule